// File: doc/BRIEF.md
# Partition Reset Sequencer

This block sequences resets for a switch whose ports are split into independent partitions. Each partition has its own state machine. A partition's ports can be reset without disturbing the ports of any other partition. Software assigns each port to a partition through a programmable map, and marks each port as upstream or downstream. The block turns several reset causes into per-port controls:

- a chip-wide fundamental reset;
- an active-low reset pin for each partition;
- a reset code written into a partition's control field;
- hot reset requests;
- secondary bus reset requests, for the upstream and the downstream direction.

The per-port controls it drives are:

- a logic reset;
- a link "go to Detect" request;
- clear strobes for the plain register class and for the sticky register class;
- hot-reset propagation onto the external link;
- a link-training enable.

The software-sticky register class is never cleared by a partition reset.

A fundamental reset walks through a fixed order, with each step lasting at least one clock:

1. logic reset;
2. link to Detect;
3. register clear;
4. a hold that lasts as long as the cause is still present.

The ports are then released to train. A side-band register gate sits between a side-band slave and the register file. The slave itself is never reset by a partition reset. While the addressed port is in logic reset, the gate answers reads with the register's default value and drops writes.

Top module: `part_rst_seq`

## Requirements
- R1: A reset of one partition asserts outputs only on ports whose `port_map` entry selects that partition. All other ports keep `port_logic_rst`, `port_detect` and both clear strobes at 0, and keep `port_train_en` at 1.
- R2: A fundamental reset starts on any of three causes. The first is `rst_n` low, which acts asynchronously and puts all ports in logic reset with training disabled. The second is a partition's `part_perst_n` bit low, passed through a two-flop synchronizer, so its effect appears after the third rising edge. The third is a partition's `part_state` field equal to 2, which takes effect after the next rising edge. Other field values have no effect.
- R3: The fundamental sequence is one cycle of logic reset alone, then one cycle adding `port_detect`, then one cycle adding `port_clr_plain` and `port_clr_sticky` together, then the hold state. The hold keeps logic reset and Detect asserted, with the strobes at 0.
- R4: The hold state persists while either the synchronized pin is low or the control field equals 2. On the first edge without a cause, the partition returns to idle: logic reset drops and `port_train_en` returns to 1. Training stays disabled during the whole fundamental sequence.
- R5: A `hot_req` pulse gives the partition's ports exactly one cycle of logic reset with `port_clr_plain`. `port_clr_sticky` stays at 0, `port_detect` stays at 0 and training stays enabled.
- R6: A `usbr_req` pulse gives one cycle of logic reset plus `port_clr_plain` to the partition's ports whose `port_is_up` bit is 0. The partition's upstream ports are untouched.
- R7: A `dsbr_req` bit on a downstream port gives one cycle of `port_hot_out` on that port alone, with no logic reset. A `dsbr_req` bit on a port whose `port_is_up` bit is 1 is ignored.
- R8: Requests arriving in the same cycle for one partition are served in a fixed priority: fundamental first, then hot, then upstream secondary bus reset, then downstream secondary bus reset. Only the winner is served, and requests that arrive while the partition is busy are dropped. A fundamental cause preempts a hot or secondary bus reset that is in progress.
- R9: While `port_logic_rst[sb_port]` is 1, `sb_rdata` equals `reg_dflt` and `reg_wr` stays 0. Otherwise `sb_rdata` equals `reg_rdata` and `reg_wr` follows `sb_wr`.
- R10: Changing a port's `port_map` entry moves that port to the resets of the newly selected partition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Chip-wide fundamental reset, active low, asynchronous |
| part_perst_n | input | NUM_PART | Per-partition reset pins, active low, asynchronous to clk |
| part_state | input | NUM_PART x CTL_W | Per-partition control field; the value CTL_RST (2) requests reset |
| hot_req | input | NUM_PART | Per-partition hot reset request pulse |
| usbr_req | input | NUM_PART | Per-partition upstream secondary bus reset request pulse |
| dsbr_req | input | NUM_PORT | Per-port downstream secondary bus reset request pulse |
| port_map | input | NUM_PORT x log2(NUM_PART) | Partition index of each port |
| port_is_up | input | NUM_PORT | 1 marks a port as its partition's upstream port |
| sb_port | input | log2(NUM_PORT) | Port addressed by the side-band access |
| sb_wr | input | 1 | Side-band write request |
| reg_rdata | input | DW | Current register value from the register file |
| reg_dflt | input | DW | Default value of the addressed register |
| port_logic_rst | output | NUM_PORT | Per-port logic reset |
| port_detect | output | NUM_PORT | Per-port force-link-to-Detect |
| port_clr_plain | output | NUM_PORT | Strobe clearing non-sticky registers |
| port_clr_sticky | output | NUM_PORT | Strobe clearing sticky-class registers |
| port_hot_out | output | NUM_PORT | Hot reset propagated on the external link |
| port_train_en | output | NUM_PORT | Link training enable |
| sb_rdata | output | DW | Side-band read data after gating |
| reg_wr | output | 1 | Write enable to the register file after gating |

## Verification
Two functions can fall in the same cycle.

- **Side-band access against a reset.** A side-band access can land on a port in the very cycle its partition enters or holds a fundamental reset. The bench provokes this by parking the partition in the hold state through its control field and then addressing one of its ports. It judges the result by requiring the default value and a suppressed write. An access to a port of an idle partition in the same cycle must still pass through untouched.
- **Competing reset requests.** Several reset kinds can be requested for one partition in the same cycle. The bench raises a hot reset, an upstream and a downstream secondary bus reset together, and then a control-field fundamental reset together with a hot reset. The clear strobes, the hot-out vector and the training enable on the cycle after must match the higher-priority request alone.

// File: rtl/prs_pkg.sv
package prs_pkg;

    typedef enum logic [2:0] {
        PS_IDLE     = 3'd0,
        PS_F_LOGIC  = 3'd1,
        PS_F_DETECT = 3'd2,
        PS_F_LOAD   = 3'd3,
        PS_F_HOLD   = 3'd4,
        PS_HOT      = 3'd5,
        PS_USBR     = 3'd6,
        PS_DSBR     = 3'd7
    } prs_state_e;

    function automatic logic is_fund(prs_state_e s);
        return (s == PS_F_LOGIC) || (s == PS_F_DETECT) ||
               (s == PS_F_LOAD)  || (s == PS_F_HOLD);
    endfunction

    function automatic logic link_held(prs_state_e s);
        return (s == PS_F_DETECT) || (s == PS_F_LOAD) || (s == PS_F_HOLD);
    endfunction

endpackage

// File: rtl/prs_sync.sv
module prs_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = din;
        sync_d.s2 = sync_q.s1;
    end

    // Reset value 0 means "pin asserted": partitions stay held until the pin is seen high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q.s2;
endmodule

// File: rtl/prs_part_fsm.sv
module prs_part_fsm
    import prs_pkg::*;
#(
    parameter int NUM_PORT = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fund_cause,
    input  logic                hot_req,
    input  logic                usbr_req,
    input  logic [NUM_PORT-1:0] dsbr_hit,
    output logic [2:0]          st_o,
    output logic [NUM_PORT-1:0] mask_o
);
    typedef struct packed {
        prs_state_e          st;
        logic [NUM_PORT-1:0] mask;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d      = fsm_q;
        fsm_d.mask = '0;
        unique case (fsm_q.st)
            PS_IDLE: begin
                if (fund_cause)       fsm_d.st = PS_F_LOGIC;
                else if (hot_req)     fsm_d.st = PS_HOT;
                else if (usbr_req)    fsm_d.st = PS_USBR;
                else if (|dsbr_hit) begin
                    fsm_d.st   = PS_DSBR;
                    fsm_d.mask = dsbr_hit;
                end
            end
            PS_F_LOGIC:  fsm_d.st = PS_F_DETECT;
            PS_F_DETECT: fsm_d.st = PS_F_LOAD;
            PS_F_LOAD:   fsm_d.st = PS_F_HOLD;
            PS_F_HOLD:   fsm_d.st = fund_cause ? PS_F_HOLD : PS_IDLE;
            PS_HOT, PS_USBR, PS_DSBR:
                         fsm_d.st = fund_cause ? PS_F_LOGIC : PS_IDLE;
            default:     fsm_d.st = PS_F_LOGIC;
        endcase
    end

    // The chip-wide reset is itself a fundamental reset: start at step one.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{st: PS_F_LOGIC, mask: '0};
        else        fsm_q <= fsm_d;
    end

    assign st_o   = fsm_q.st;
    assign mask_o = fsm_q.mask;
endmodule

// File: rtl/prs_port_fan.sv
module prs_port_fan
    import prs_pkg::*;
#(
    parameter int NUM_PART = 4,
    parameter int NUM_PORT = 8
) (
    input  logic [NUM_PART-1:0][2:0]                   st_vec,
    input  logic [NUM_PART-1:0][NUM_PORT-1:0]          mask_vec,
    input  logic [NUM_PORT-1:0][$clog2(NUM_PART)-1:0]  port_map,
    input  logic [NUM_PORT-1:0]                        port_is_up,
    output logic [NUM_PORT-1:0]                        logic_rst,
    output logic [NUM_PORT-1:0]                        detect,
    output logic [NUM_PORT-1:0]                        clr_plain,
    output logic [NUM_PORT-1:0]                        clr_sticky,
    output logic [NUM_PORT-1:0]                        hot_out,
    output logic [NUM_PORT-1:0]                        train_en
);
    localparam int PW = $clog2(NUM_PART);

    always_comb begin
        logic_rst  = '0;
        detect     = '0;
        clr_plain  = '0;
        clr_sticky = '0;
        hot_out    = '0;
        train_en   = '1;
        for (int p = 0; p < NUM_PORT; p++) begin
            for (int k = 0; k < NUM_PART; k++) begin
                prs_state_e s;
                logic       sel;
                logic       usb_hit;
                s       = prs_state_e'(st_vec[k]);
                sel     = (port_map[p] == PW'(k));
                usb_hit = (s == PS_USBR) && !port_is_up[p];
                if (sel) begin
                    logic_rst[p]  = logic_rst[p] | is_fund(s) | (s == PS_HOT) | usb_hit;
                    detect[p]     = detect[p] | link_held(s);
                    clr_plain[p]  = clr_plain[p] | (s == PS_F_LOAD) | (s == PS_HOT) | usb_hit;
                    clr_sticky[p] = clr_sticky[p] | (s == PS_F_LOAD);
                    hot_out[p]    = hot_out[p] | ((s == PS_DSBR) && mask_vec[k][p]);
                    train_en[p]   = train_en[p] & !is_fund(s);
                end
            end
        end
    end
endmodule

// File: rtl/prs_sb_gate.sv
module prs_sb_gate #(
    parameter int NUM_PORT = 8,
    parameter int DW       = 32
) (
    input  logic [NUM_PORT-1:0]         port_busy,
    input  logic [$clog2(NUM_PORT)-1:0] sb_port,
    input  logic                        sb_wr,
    input  logic [DW-1:0]               reg_rdata,
    input  logic [DW-1:0]               reg_dflt,
    output logic [DW-1:0]               sb_rdata,
    output logic                        reg_wr
);
    // Purely combinational: holds no state, so no partition reset can reach it.
    always_comb begin
        logic busy;
        busy     = port_busy[sb_port];
        sb_rdata = busy ? reg_dflt : reg_rdata;
        reg_wr   = sb_wr && !busy;
    end
endmodule

// File: rtl/part_rst_seq.sv
module part_rst_seq #(
    parameter int NUM_PART = 4,
    parameter int NUM_PORT = 8,
    parameter int CTL_W    = 2,
    parameter int CTL_RST  = 2,
    parameter int DW       = 32
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic [NUM_PART-1:0]                       part_perst_n,
    input  logic [NUM_PART-1:0][CTL_W-1:0]            part_state,
    input  logic [NUM_PART-1:0]                       hot_req,
    input  logic [NUM_PART-1:0]                       usbr_req,
    input  logic [NUM_PORT-1:0]                       dsbr_req,
    input  logic [NUM_PORT-1:0][$clog2(NUM_PART)-1:0] port_map,
    input  logic [NUM_PORT-1:0]                       port_is_up,
    input  logic [$clog2(NUM_PORT)-1:0]               sb_port,
    input  logic                                      sb_wr,
    input  logic [DW-1:0]                             reg_rdata,
    input  logic [DW-1:0]                             reg_dflt,
    output logic [NUM_PORT-1:0]                       port_logic_rst,
    output logic [NUM_PORT-1:0]                       port_detect,
    output logic [NUM_PORT-1:0]                       port_clr_plain,
    output logic [NUM_PORT-1:0]                       port_clr_sticky,
    output logic [NUM_PORT-1:0]                       port_hot_out,
    output logic [NUM_PORT-1:0]                       port_train_en,
    output logic [DW-1:0]                             sb_rdata,
    output logic                                      reg_wr
);
    localparam int PW = $clog2(NUM_PART);
    localparam logic [CTL_W-1:0] RST_CODE = CTL_W'(CTL_RST);

    logic [NUM_PART-1:0]                perst_sync;
    logic [NUM_PART-1:0]                fund_cause;
    logic [NUM_PART-1:0][NUM_PORT-1:0]  dsbr_hit;
    logic [NUM_PART-1:0][2:0]           st_vec;
    logic [NUM_PART-1:0][NUM_PORT-1:0]  mask_vec;

    prs_sync #(.W(NUM_PART)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (part_perst_n),
        .dout  (perst_sync)
    );

    always_comb begin
        for (int k = 0; k < NUM_PART; k++) begin
            fund_cause[k] = !perst_sync[k] || (part_state[k] == RST_CODE);
            for (int p = 0; p < NUM_PORT; p++)
                dsbr_hit[k][p] = dsbr_req[p] && !port_is_up[p] && (port_map[p] == PW'(k));
        end
    end

    for (genvar k = 0; k < NUM_PART; k++) begin : g_part
        prs_part_fsm #(.NUM_PORT(NUM_PORT)) u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .fund_cause (fund_cause[k]),
            .hot_req    (hot_req[k]),
            .usbr_req   (usbr_req[k]),
            .dsbr_hit   (dsbr_hit[k]),
            .st_o       (st_vec[k]),
            .mask_o     (mask_vec[k])
        );
    end

    prs_port_fan #(.NUM_PART(NUM_PART), .NUM_PORT(NUM_PORT)) u_fan (
        .st_vec     (st_vec),
        .mask_vec   (mask_vec),
        .port_map   (port_map),
        .port_is_up (port_is_up),
        .logic_rst  (port_logic_rst),
        .detect     (port_detect),
        .clr_plain  (port_clr_plain),
        .clr_sticky (port_clr_sticky),
        .hot_out    (port_hot_out),
        .train_en   (port_train_en)
    );

    prs_sb_gate #(.NUM_PORT(NUM_PORT), .DW(DW)) u_gate (
        .port_busy (port_logic_rst),
        .sb_port   (sb_port),
        .sb_wr     (sb_wr),
        .reg_rdata (reg_rdata),
        .reg_dflt  (reg_dflt),
        .sb_rdata  (sb_rdata),
        .reg_wr    (reg_wr)
    );
endmodule

// File: rtl/prs_checker.sv
module prs_checker #(
    parameter int NUM_PORT = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_PORT-1:0]         logic_rst,
    input logic [NUM_PORT-1:0]         detect,
    input logic [NUM_PORT-1:0]         clr_plain,
    input logic [NUM_PORT-1:0]         clr_sticky,
    input logic [NUM_PORT-1:0]         hot_out,
    input logic [NUM_PORT-1:0]         train_en,
    input logic [NUM_PORT-1:0]         is_up,
    input logic [$clog2(NUM_PORT)-1:0] sb_port,
    input logic                        sb_wr,
    input logic                        reg_wr
);
    for (genvar p = 0; p < NUM_PORT; p++) begin : g_port
        a_r3_detect_after_logic: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(detect[p]) |-> $past(logic_rst[p]));
        a_r3_load_inside_detect: assert property (@(posedge clk) disable iff (!rst_n)
            clr_sticky[p] |-> (detect[p] && logic_rst[p] && clr_plain[p]));
        a_r3_sticky_single: assert property (@(posedge clk) disable iff (!rst_n)
            clr_sticky[p] |=> !clr_sticky[p]);
        a_r4_train_off_in_detect: assert property (@(posedge clk) disable iff (!rst_n)
            train_en[p] |-> !detect[p]);
        a_r5_hot_no_detect: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_plain[p] && !clr_sticky[p]) |-> (!detect[p] && train_en[p]));
        a_r7_hot_out_down_only: assert property (@(posedge clk) disable iff (!rst_n)
            hot_out[p] |-> (!is_up[p] && !logic_rst[p]));
    end

    a_r9_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_wr && logic_rst[sb_port]) |-> !reg_wr);
endmodule

bind part_rst_seq prs_checker #(.NUM_PORT(NUM_PORT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .logic_rst  (port_logic_rst),
    .detect     (port_detect),
    .clr_plain  (port_clr_plain),
    .clr_sticky (port_clr_sticky),
    .hot_out    (port_hot_out),
    .train_en   (port_train_en),
    .is_up      (port_is_up),
    .sb_port    (sb_port),
    .sb_wr      (sb_wr),
    .reg_wr     (reg_wr)
);

// File: tb/part_rst_seq_tb.sv
`timescale 1ns/1ps
module part_rst_seq_tb;
    logic             clk = 1'b0;
    logic             rst_n;
    logic [3:0]       part_perst_n;
    logic [3:0][1:0]  part_state;
    logic [3:0]       hot_req, usbr_req;
    logic [7:0]       dsbr_req;
    logic [7:0][1:0]  port_map;
    logic [7:0]       port_is_up;
    logic [2:0]       sb_port;
    logic             sb_wr;
    logic [31:0]      reg_rdata, reg_dflt;
    logic [7:0]       port_logic_rst, port_detect, port_clr_plain, port_clr_sticky;
    logic [7:0]       port_hot_out, port_train_en;
    logic [31:0]      sb_rdata;
    logic             reg_wr;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    part_rst_seq u_dut (.*);

    always @(posedge clk) begin
        cycles++;
        if (cycles == 20000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(); tick();
        chk("R2 rst_n logic_rst", 32'(port_logic_rst), 32'hFF);
        chk("R2 rst_n train_en", 32'(port_train_en), 32'h00);
        rst_n = 1'b1;
        repeat (8) tick();
        chk("R4 idle logic_rst", 32'(port_logic_rst), 32'h00);
        chk("R4 idle train_en", 32'(port_train_en), 32'hFF);
        chk("R4 idle detect", 32'(port_detect), 32'h00);
    endtask

    task automatic t_ctl_fund();
        part_state[1] = 2'd2;
        tick();
        chk("R3 step1 logic_rst", 32'(port_logic_rst), 32'h0C);
        chk("R3 step1 detect", 32'(port_detect), 32'h00);
        chk("R1 isolation train_en", 32'(port_train_en), 32'hF3);
        tick();
        chk("R3 step2 detect", 32'(port_detect), 32'h0C);
        chk("R3 step2 no clear", 32'(port_clr_sticky), 32'h00);
        tick();
        chk("R3 step3 clr_plain", 32'(port_clr_plain), 32'h0C);
        chk("R3 step3 clr_sticky", 32'(port_clr_sticky), 32'h0C);
        repeat (6) tick();
        chk("R4 hold detect", 32'(port_detect), 32'h0C);
        chk("R4 hold strobes off", 32'(port_clr_plain), 32'h00);
        // R9: side-band access coinciding with the hold
        sb_wr = 1'b1; reg_rdata = 32'hAAAA_0001; reg_dflt = 32'h5555_0002;
        sb_port = 3'd2; #1;
        chk("R9 read default", sb_rdata, 32'h5555_0002);
        chk("R9 write dropped", 32'(reg_wr), 32'h0);
        sb_port = 3'd0; #1;
        chk("R9 idle read passes", sb_rdata, 32'hAAAA_0001);
        chk("R9 idle write passes", 32'(reg_wr), 32'h1);
        sb_wr = 1'b0;
        part_state[1] = 2'd1;          // code 1 is not the reset code
        tick();
        chk("R4 release train_en", 32'(port_train_en), 32'hFF);
        chk("R2 non-reset code", 32'(port_logic_rst), 32'h00);
        part_state[1] = 2'd0;
    endtask

    task automatic t_pin_fund();
        part_perst_n[2] = 1'b0;
        tick(); tick();
        chk("R2 pin sync latency", 32'(port_logic_rst), 32'h00);
        tick();
        chk("R2 pin reset", 32'(port_logic_rst), 32'h30);
        repeat (6) tick();
        chk("R4 pin hold", 32'(port_detect), 32'h30);
        part_perst_n[2] = 1'b1;
        tick(); tick();
        chk("R4 still held during sync", 32'(port_detect), 32'h30);
        tick();
        chk("R4 pin release", 32'(port_train_en), 32'hFF);
    endtask

    task automatic t_hot();
        hot_req[0] = 1'b1;
        tick();
        hot_req[0] = 1'b0;
        chk("R5 hot logic_rst", 32'(port_logic_rst), 32'h03);
        chk("R5 hot clr_plain", 32'(port_clr_plain), 32'h03);
        chk("R5 hot no sticky", 32'(port_clr_sticky), 32'h00);
        chk("R5 hot no detect", 32'(port_detect), 32'h00);
        chk("R5 hot train on", 32'(port_train_en), 32'hFF);
        tick();
        chk("R5 hot one cycle", 32'(port_logic_rst), 32'h00);
    endtask

    task automatic t_usbr();
        usbr_req[3] = 1'b1;
        tick();
        usbr_req[3] = 1'b0;
        chk("R6 usbr logic_rst", 32'(port_logic_rst), 32'h80);
        chk("R6 usbr clr_plain", 32'(port_clr_plain), 32'h80);
        tick();
        chk("R6 usbr done", 32'(port_logic_rst), 32'h00);
    endtask

    task automatic t_dsbr();
        dsbr_req = 8'h0C;
        tick();
        dsbr_req = 8'h00;
        chk("R7 dsbr hot_out", 32'(port_hot_out), 32'h08);
        chk("R7 dsbr no logic_rst", 32'(port_logic_rst), 32'h00);
        tick();
        chk("R7 dsbr one cycle", 32'(port_hot_out), 32'h00);
        dsbr_req = 8'h04;
        tick();
        dsbr_req = 8'h00;
        chk("R7 upstream ignored", 32'(port_hot_out), 32'h00);
    endtask

    task automatic t_prio();
        hot_req[0] = 1'b1; usbr_req[0] = 1'b1; dsbr_req = 8'h02;
        tick();
        hot_req[0] = 1'b0; usbr_req[0] = 1'b0; dsbr_req = 8'h00;
        chk("R8 hot beats usbr", 32'(port_clr_plain), 32'h03);
        chk("R8 hot beats dsbr", 32'(port_hot_out), 32'h00);
        tick();
        part_state[0] = 2'd2; hot_req[0] = 1'b1;
        tick();
        part_state[0] = 2'd0; hot_req[0] = 1'b0;
        chk("R8 fund beats hot strobe", 32'(port_clr_plain), 32'h00);
        chk("R8 fund beats hot train", 32'(port_train_en), 32'hFC);
        repeat (4) tick();
        chk("R8 fund completes", 32'(port_train_en), 32'hFF);
    endtask

    task automatic t_remap();
        port_map[7] = 2'd0;
        hot_req[0] = 1'b1;
        tick();
        hot_req[0] = 1'b0;
        chk("R10 remapped port", 32'(port_logic_rst), 32'h83);
        port_map[7] = 2'd3;
        tick();
    endtask

    initial begin
        rst_n = 1'b0; part_perst_n = '1; part_state = '0;
        hot_req = '0; usbr_req = '0; dsbr_req = '0;
        for (int p = 0; p < 8; p++) port_map[p] = 2'(p / 2);
        port_is_up = 8'h55;
        sb_port = '0; sb_wr = 1'b0; reg_rdata = '0; reg_dflt = '0;
        t_reset();
        t_ctl_fund();
        t_pin_fund();
        t_hot();
        t_usbr();
        t_dsbr();
        t_prio();
        t_remap();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule